// File: doc/BRIEF.md
# Paged Scrambled-Sequence Program Counter

This block produces the instruction fetch address of a small 4-bit controller. The address is 11 bits wide. A 5-bit page register forms the upper bits and a 6-bit address part forms the lower bits. The address part does not count in binary. On each instruction cycle it moves one step along a fixed scrambled loop. The loop is a left-shift sequence with linear feedback plus a correction term, so every one of the 64 codes appears exactly once per lap.

The loop has no start and no end, and it never carries into the page. Code running within one page therefore stays in that page until the program loads a new page. An advance strobe marks each instruction cycle. A hold input lets a two-cycle instruction keep the address part where it is. Separate load ports set the page and the address part. An address load takes priority over both advance and hold.

Top module: `ppc_top`

## Requirements
- R1: When rst is high at a rising clock edge, the page and the address part both clear to 0, so pc_o reads 0 after that edge.
- R2: A page load (page_ld_i=1) stores any value from 0 to 31 from page_d_i. Without a page load the page never changes, and that includes the moment the address part wraps around its loop.
- R3: An advance step happens when adv_i=1, hold_i=0 and addr_ld_i=0. In a step the new address part is the old one shifted left by one bit. Old bits [4:0] become new bits [5:1], and a computed feedback bit enters at bit 0.
- R4: Starting from 0, 64 consecutive advance steps visit all 64 codes exactly once and then return to 0.
- R5: The loop contains the runs 0→1→3→7→15 and 63→62→61.
- R6: While hold_i=1 and addr_ld_i=0, the address part keeps its value even when adv_i=1.
- R7: An address load (addr_ld_i=1) stores addr_d_i into the address part. It wins over adv_i and over hold_i.
- R8: With adv_i=0 and addr_ld_i=0, the address part keeps its value.
- R9: pc_o carries the page in bits [10:6] and the address part in bits [5:0]. Both come straight from registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | One instruction cycle has completed; advance the address part |
| hold_i | input | 1 | Stall the address part (second cycle of a two-cycle instruction) |
| page_ld_i | input | 1 | Load the page register |
| page_d_i | input | 5 | New page value |
| addr_ld_i | input | 1 | Load the address part |
| addr_d_i | input | 6 | New address-part value |
| pc_o | output | 11 | Fetch address: {page, address part} |

## Verification
The assertions check four things on every cycle: each step has the left-shift form, hold and idle leave the address part unchanged, a load beats both advance and hold, and the page moves only when loaded. Three things can only be shown by the bench scenarios, because each is a property of a whole run and not of one edge. These are that the loop covers all 64 codes and closes after exactly 64 steps, that the known runs (0→1→3→7→15 and 63→62→61) occur, and that the page stays put across the wrap at page 31.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int PAGE_W = 5;
  localparam int ADDR_W = 6;
  localparam int PC_W   = PAGE_W + ADDR_W;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PC_W-1:0]   pc_t;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } addr_act_e;
endpackage

// File: rtl/ppc_seq_step.sv
module ppc_seq_step #(
  parameter int W          = 6,
  parameter int TAP_HI     = 5,
  parameter int TAP_LO     = 4,
  parameter bit FULL_CYCLE = 1'b1
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  localparam int LOW_W = W - 1;

  logic fb;
  logic fix;
  logic ins;

  // XNOR feedback: the all-ones word is the state it would lock up in.
  assign fb = ~(cur_i[TAP_HI] ^ cur_i[TAP_LO]);

  generate
    if (FULL_CYCLE) begin : g_full
      // Invert the inserted bit whenever the low bits are all ones.
      // This splices the all-ones word into the loop.
      assign fix = &cur_i[LOW_W-1:0];
    end else begin : g_plain
      assign fix = 1'b0;
    end
  endgenerate

  assign ins   = fb ^ fix;
  assign nxt_o = {cur_i[LOW_W-1:0], ins};
endmodule

// File: rtl/ppc_page_reg.sv
module ppc_page_reg
  import ppc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ld_i,
  input  page_t d_i,
  output page_t q_o
);
  page_t q;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (ld_i) q <= d_i;
  end

  assign q_o = q;

  p_page_only_by_load_r2: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> $stable(q));

  p_page_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> q == $past(d_i));
endmodule

// File: rtl/ppc_addr_part.sv
module ppc_addr_part
  import ppc_pkg::*;
#(
  parameter int TAP_HI = 5,
  parameter int TAP_LO = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv_i,
  input  logic  hold_i,
  input  logic  ld_i,
  input  addr_t d_i,
  output addr_t q_o
);
  addr_t     q;
  addr_t     nxt;
  addr_act_e act;

  ppc_seq_step #(
    .W(ADDR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .FULL_CYCLE(1'b1)
  ) u_step (
    .cur_i(q),
    .nxt_o(nxt)
  );

  always_comb begin
    if (ld_i)                 act = ACT_LOAD;
    else if (adv_i && !hold_i) act = ACT_STEP;
    else                      act = ACT_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (act)
        ACT_LOAD: q <= d_i;
        ACT_STEP: q <= nxt;
        default:  q <= q;
      endcase
    end
  end

  assign q_o = q;

  p_shift_form_r3: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !hold_i && !ld_i) |=> q[ADDR_W-1:1] == $past(q[ADDR_W-2:0]));

  p_step_moves_r4: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !hold_i && !ld_i) |=> q != $past(q));

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !ld_i) |=> $stable(q));

  p_load_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> q == $past(d_i));

  p_idle_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !ld_i) |=> $stable(q));

  p_ones_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (q == '1 && adv_i && !hold_i && !ld_i) |=> q == addr_t'({ADDR_W-1{1'b1}} << 1));
endmodule

// File: rtl/ppc_top.sv
module ppc_top
  import ppc_pkg::*;
#(
  parameter int TAP_HI = 5,
  parameter int TAP_LO = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv_i,
  input  logic                    hold_i,
  input  logic                    page_ld_i,
  input  logic [PAGE_W-1:0]       page_d_i,
  input  logic                    addr_ld_i,
  input  logic [ADDR_W-1:0]       addr_d_i,
  output logic [PC_W-1:0]         pc_o
);
  page_t page_q;
  addr_t addr_q;

  ppc_page_reg u_page (
    .clk (clk),
    .rst (rst),
    .ld_i(page_ld_i),
    .d_i (page_d_i),
    .q_o (page_q)
  );

  ppc_addr_part #(.TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .adv_i (adv_i),
    .hold_i(hold_i),
    .ld_i  (addr_ld_i),
    .d_i   (addr_d_i),
    .q_o   (addr_q)
  );

  assign pc_o = {page_q, addr_q};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> pc_o == '0);

  p_no_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (!page_ld_i && addr_q == '1) |=> pc_o[PC_W-1:ADDR_W] == $past(page_q));
endmodule

// File: tb/ppc_top_tb_top.sv
module ppc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_i = 1'b0;
  logic        hold_i = 1'b0;
  logic        page_ld_i = 1'b0;
  logic [4:0]  page_d_i = '0;
  logic        addr_ld_i = 1'b0;
  logic [5:0]  addr_d_i = '0;
  logic [10:0] pc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ppc_top dut_i (
    .clk(clk), .rst(rst), .adv_i(adv_i), .hold_i(hold_i),
    .page_ld_i(page_ld_i), .page_d_i(page_d_i),
    .addr_ld_i(addr_ld_i), .addr_d_i(addr_d_i), .pc_o(pc_o)
  );

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs change at negedge, the design updates at posedge, outputs are read at the next negedge.
  task automatic cyc(input logic r, input logic a, input logic h,
                     input logic pl, input logic [4:0] pd,
                     input logic al, input logic [5:0] ad);
    rst = r; adv_i = a; hold_i = h;
    page_ld_i = pl; page_d_i = pd; addr_ld_i = al; addr_d_i = ad;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; adv_i = 1'b0; hold_i = 1'b0; page_ld_i = 1'b0; addr_ld_i = 1'b0;
  endtask

  task automatic step();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 6'd0);
  endtask

  task automatic t_reset();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 5'd9, 1'b1, 6'd33);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 6'd0);
    chk("R1 reset clears pc", pc_o, 11'd0);
  endtask

  task automatic t_walk(input logic [4:0] pg);
    bit seen [64];
    logic [5:0] prev;
    int dup = 0;
    int bad_shift = 0;
    int page_moves = 0;
    cyc(1'b0, 1'b0, 1'b0, 1'b1, pg, 1'b1, 6'd0);
    chk("R9 page in upper bits", pc_o, {pg, 6'd0});
    for (int i = 0; i < 64; i++) begin
      prev = pc_o[5:0];
      if (seen[prev]) dup++;
      seen[prev] = 1'b1;
      step();
      if (pc_o[5:1] !== prev[4:0]) bad_shift++;
      if (pc_o[10:6] !== pg) page_moves++;
    end
    chk("R3 every step is a left shift", 11'(bad_shift), 11'd0);
    chk("R4 no code repeats within a lap", 11'(dup), 11'd0);
    chk("R4 lap closes at start after 64 steps", pc_o, {pg, 6'd0});
    chk("R2 page unchanged through wrap", 11'(page_moves), 11'd0);
  endtask

  task automatic t_known();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 6'd0);
    step(); chk("R5 0 to 1", pc_o, 11'd1);
    step(); chk("R5 1 to 3", pc_o, 11'd3);
    step(); chk("R5 3 to 7", pc_o, 11'd7);
    step(); chk("R5 7 to 15", pc_o, 11'd15);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 6'd63);
    chk("R7 load 63", pc_o, 11'd63);
    step(); chk("R5 63 to 62", pc_o, 11'd62);
    step(); chk("R5 62 to 61", pc_o, 11'd61);
  endtask

  task automatic t_hold_idle();
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 1'b1, 6'd7);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 6'd0);
    chk("R6 hold with advance stalls", pc_o, {5'd3, 6'd7});
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 6'd0);
    chk("R8 idle keeps value", pc_o, {5'd3, 6'd7});
    step();
    chk("R6 resumes after hold", pc_o, {5'd3, 6'd15});
  endtask

  task automatic t_load_prio();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 6'd42);
    chk("R7 load beats advance", pc_o[5:0], 11'd42);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 6'd21);
    chk("R7 load beats hold", pc_o[5:0], 11'd21);
  endtask

  task automatic t_page();
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 5'd31, 1'b1, 6'd5);
    chk("R2 page loads 31", pc_o[10:6], 11'd31);
    for (int i = 0; i < 10; i++) step();
    chk("R2 page kept over steps", pc_o[10:6], 11'd31);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 6'd0);
    chk("R2 page loads 0", pc_o[10:6], 11'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_walk(5'd0);
    t_walk(5'd31);
    t_known();
    t_hold_idle();
    t_load_prio();
    t_page();
    t_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule